// File: doc/BRIEF.md
# Duty-Cycle Pulse Tone Channel

This block produces a square-wave tone with a selectable duty width and a 4-bit level. Three byte-wide control registers are loaded over a small address/data/strobe bus. A 12-bit period divider steps a 16-position phase counter. A duty comparison turns the phase into an on/off pulse, and while the pulse is on the output carries the programmed volume.

Two control bits cut across the tone path. A gate bit holds the output at the volume level and freezes the phase. An enable bit silences the channel. The 4-bit output amplitude goes to a mixer outside this block. The divider and the sequencer stop whenever a tone could not be heard or the period is too short to be useful.

Top module: `pulse_tone_channel`

## Requirements
- R1: A synchronous active-high reset clears all three registers, sets the phase to 1 and drives the amplitude to 0.
- R2: A write with the strobe high stores the data byte in register 0, 1 or 2 as the address selects, at that rising edge. A write to address 3 changes no register.
- R3: When register 2 bit 7 (enable) is 0, the amplitude is 0 whatever the other fields hold.
- R4: Register 0 bits [6:4] give a duty code, and the duty width is the code plus 1 (1 to 8). With the gate clear and the channel enabled, the amplitude equals register 0 bits [3:0] (the volume) while phase < duty width, and is 0 otherwise.
- R5: When register 0 bit 7 (gate) is 1 and the channel is enabled, the amplitude equals the volume on every cycle, and the phase holds its value.
- R6: The phase advances only while the channel is enabled, the volume is nonzero, the gate is clear and the period is greater than 4.
- R7: While the phase is advancing, it moves up by one every period+1 clocks, and it wraps from 15 to 0.
- R8: The 12-bit period is register 2 bits [3:0] as the high nibble joined to register 1 as the low byte.
- R9: While the phase is stopped, the divider holds the current period, so the first step after the phase restarts comes period+1 clocks after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0, 1 or 2; 3 is unused) |
| wr_data | input | 8 | Byte to be written |
| amp_o | output | 4 | Output amplitude of the channel |

## Verification
A divider that reloads one count early or late shifts every later pulse edge. The amplitude then disagrees with the reference within one phase step, at most period+1 clocks, and the error grows with each step after that. A wrong phase value shows as a pulse of the wrong width or position within one 16-step cycle. A missed wrap, or a phase that drifts while the gate is set or a halt condition holds, shows as soon as the tone resumes. The reference runs clock by clock, so the first wrong cycle is reported, not only a wrong waveform at the end.

// File: rtl/pulse_tone_pkg.sv
package pulse_tone_pkg;
  localparam int REG_W          = 8;
  localparam int NUM_REGS       = 3;
  localparam int ADDR_W         = 2;
  localparam int VOL_W          = 4;
  localparam int DUTY_W         = 3;
  localparam int PER_W          = 12;
  localparam int PER_HI_W       = PER_W - REG_W;
  localparam int PH_STEPS       = 16;
  localparam int PH_W           = $clog2(PH_STEPS);
  localparam int DW             = PH_W + 1;
  localparam int MIN_RUN_PERIOD = 4;
  localparam int PH_INIT        = 1;
  localparam int EN_BIT         = REG_W - 1;

  typedef struct packed {
    logic              gate;
    logic [DUTY_W-1:0] duty_code;
    logic [VOL_W-1:0]  vol;
  } tone_ctl_t;

  typedef logic [PER_W-1:0] period_t;
  typedef logic [PH_W-1:0]  phase_t;

  function automatic logic [DW-1:0] duty_width(input logic [DUTY_W-1:0] code);
    return DW'(code) + DW'(1);
  endfunction

  function automatic logic pulse_on(input phase_t ph, input logic [DUTY_W-1:0] code);
    return DW'(ph) < duty_width(code);
  endfunction

  function automatic logic may_step(input tone_ctl_t c, input logic en, input period_t per);
    return en && (c.vol != '0) && !c.gate && (per > period_t'(MIN_RUN_PERIOD));
  endfunction

  function automatic logic [VOL_W-1:0] out_level(input tone_ctl_t c, input logic en,
                                                 input phase_t ph);
    if (!en) return '0;
    if (c.gate || pulse_on(ph, c.duty_code)) return c.vol;
    return '0;
  endfunction
endpackage

// File: rtl/pt_regfile.sv
module pt_regfile
  import pulse_tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output tone_ctl_t         ctl_o,
  output period_t           period_o,
  output logic              enable_o
);
  logic [REG_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                    regs[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))    regs[i] <= wr_data;
    end
  end

  assign ctl_o    = tone_ctl_t'(regs[0]);
  assign period_o = {regs[2][PER_HI_W-1:0], regs[1]};
  assign enable_o = regs[2][EN_BIT];

  logic unused_addr;
  assign unused_addr = wr_en && (int'(wr_addr) >= NUM_REGS);

  a_r2_unused_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    unused_addr |=> ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[2])));
endmodule

// File: rtl/pt_divider.sv
module pt_divider
  import pulse_tone_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    run_i,
  input  period_t period_i,
  output logic    step_o
);
  period_t cnt;
  logic    expire;

  assign expire = (cnt == '0);
  assign step_o = run_i && expire;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (!run_i || expire) cnt <= period_i;
    else                      cnt <= cnt - PER_W'(1);
  end

  a_r7_reload_on_step: assert property (@(posedge clk) disable iff (rst)
    step_o |=> cnt == $past(period_i));
  a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
    (run_i && !expire) |=> cnt == $past(cnt) - PER_W'(1));
  a_r9_idle_preload: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> cnt == $past(period_i));
endmodule

// File: rtl/pt_sequencer.sv
module pt_sequencer
  import pulse_tone_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step_i,
  output phase_t phase_o
);
  phase_t phase;
  logic   at_last;

  assign at_last = (phase == PH_W'(PH_STEPS - 1));
  assign phase_o = phase;

  always_ff @(posedge clk) begin
    if (rst)         phase <= PH_W'(PH_INIT);
    else if (step_i) phase <= at_last ? '0 : phase + PH_W'(1);
  end

  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (step_i && at_last) |=> phase == '0);
  a_r6_hold_without_step: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(phase));
endmodule

// File: rtl/pt_level.sv
module pt_level
  import pulse_tone_pkg::*;
(
  input  tone_ctl_t        ctl_i,
  input  logic             enable_i,
  input  phase_t           phase_i,
  output logic [VOL_W-1:0] amp_o
);
  assign amp_o = out_level(ctl_i, enable_i, phase_i);
endmodule

// File: rtl/pulse_tone_channel.sv
module pulse_tone_channel
  import pulse_tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [VOL_W-1:0]  amp_o
);
  tone_ctl_t ctl;
  period_t   period;
  logic      enable;
  logic      run;
  logic      step;
  phase_t    phase;

  pt_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_o(ctl), .period_o(period), .enable_o(enable)
  );

  assign run = may_step(ctl, enable, period);

  pt_divider u_div (
    .clk(clk), .rst(rst), .run_i(run), .period_i(period), .step_o(step)
  );

  pt_sequencer u_seq (
    .clk(clk), .rst(rst), .step_i(step), .phase_o(phase)
  );

  pt_level u_lvl (
    .ctl_i(ctl), .enable_i(enable), .phase_i(phase), .amp_o(amp_o)
  );

  a_r3_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    !enable |-> amp_o == '0);
  a_r4_two_levels: assert property (@(posedge clk) disable iff (rst)
    (amp_o == '0) || (amp_o == ctl.vol));
  a_r5_gate_holds_phase: assert property (@(posedge clk) disable iff (rst)
    ctl.gate |=> $stable(phase) || $past(rst));
  a_r6_no_step_when_halted: assert property (@(posedge clk) disable iff (rst)
    !run |-> !step);
endmodule

// File: tb/tb_pulse_tone_channel.sv
module tb_pulse_tone_channel;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] amp_o;

  int n_vec = 0;
  int n_miss = 0;
  string tag = "R1";

  int m_reg[3];
  int m_phase;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_tone_channel dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .amp_o(amp_o)
  );

  function automatic int m_period();
    return ((m_reg[2] & 15) << 8) | m_reg[1];
  endfunction

  function automatic int m_amp();
    int vol  = m_reg[0] & 15;
    int gate = (m_reg[0] >> 7) & 1;
    int duty = ((m_reg[0] >> 4) & 7) + 1;
    int en   = (m_reg[2] >> 7) & 1;
    if (en == 0) return 0;
    if (gate == 1 || m_phase < duty) return vol;
    return 0;
  endfunction

  function automatic bit m_run();
    return ((m_reg[2] >> 7) & 1) == 1 && (m_reg[0] & 15) != 0 &&
           ((m_reg[0] >> 7) & 1) == 0 && m_period() > 4;
  endfunction

  task automatic model_edge();
    if (rst) begin
      for (int i = 0; i < 3; i++) m_reg[i] = 0;
      m_phase = 1;
      m_cnt = 0;
    end else begin
      if (!m_run()) m_cnt = m_period();
      else if (m_cnt == 0) begin
        m_phase = (m_phase + 1) % 16;
        m_cnt = m_period();
      end else m_cnt = m_cnt - 1;
      if (wr_en && wr_addr < 3) m_reg[wr_addr] = wr_data;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_vec++;
    if (int'(amp_o) != m_amp()) begin
      n_miss++;
      $display("FAIL %s t=%0t amp actual=%0d expected=%0d", tag, $time, amp_o, m_amp());
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_miss++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    tag = "R1"; rst = 1'b1; idle(3);
    rst = 1'b0; idle(5);
    // R1: duty 1 with reset phase 1 must stay low until the wrap
    tag = "R1"; wr(1, 5); wr(2, 8'h80); wr(0, 8'h0F); idle(20);
    tag = "R7"; idle(200);
    tag = "R4";
    for (int d = 1; d < 8; d++) begin
      wr(0, (d << 4) | 10);
      idle(120);
    end
    tag = "R8"; wr(1, 8'h02); wr(2, 8'h81); idle(1300);
    tag = "R6"; wr(2, 8'h80); idle(50);
    wr(1, 4); idle(50);
    tag = "R9"; wr(1, 6); idle(150);
    tag = "R6"; wr(0, 8'h30); idle(60);
    tag = "R9"; wr(0, 8'h35); idle(100);
    tag = "R5"; wr(0, 8'hB7); idle(100);
    tag = "R9"; wr(0, 8'h37); idle(120);
    tag = "R3"; wr(2, 8'h00); idle(60);
    wr(0, 8'hBF); idle(20);
    tag = "R3"; wr(2, 8'h80); idle(20);
    tag = "R2"; wr(0, 8'h74); idle(100);
    wr(3, 8'h00); idle(60);
    wr(3, 8'hFF); idle(60);
    wr(1, 8'h09); idle(200);
    tag = "R1"; rst = 1'b1; idle(2);
    rst = 1'b0; idle(30);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule